// File: doc/BRIEF.md
# Clock Control Register Bank

This block is the configuration store of a clock control unit. It sits on a simple 32-bit word-oriented bus with one-cycle write and read strobes. It holds eight writable configuration words: a mode word, two post-divider words, two PLL control words and three clock-gating words. It also answers reads of a fixed power-management word and of a constant status word. Each write is filtered through the mask of its word, and the mode word also has one bit that is always set. The stored values leave the block on dedicated configuration outputs.

The block does not generate clocks and does not gate them. A separate frequency calculator reads the configuration outputs. It needs to know when these values may have changed, so the block drives a one-cycle recompute request. A small notification state machine produces this request. It is raised once just after reset and again after every write to a word that affects frequency. The machine has three states. ST_BOOT is held during reset. ST_NOTIFY drives the request. ST_IDLE waits. Its transitions are:

- boot_done (ST_BOOT to ST_NOTIFY) is unconditional on the first clock edge after reset.
- renotify (ST_NOTIFY to ST_NOTIFY) and wake (ST_IDLE to ST_NOTIFY) are taken on a frequency-relevant write.
- settle (ST_NOTIFY to ST_IDLE) is taken when there is no such write.
- ST_IDLE stays in ST_IDLE when there is no such write.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, reads return these values: word 0 0x074b0b7b, word 1 0xff870b48, word 2 0x49fcfe7f, word 4 0x04001800, word 6 0x04043001, words 8/9/10 0xffffffff, word 23 0x80209828. The configuration outputs show the same values.
- R2: A write to word 0 (mode) stores (data & 0x3b6fdfff) | 0x04000000, so bit 26 always reads 1.
- R3: A write to word 1 stores data & 0xff9f3fff. A write to word 2 stores the full data.
- R4: A write to word 4 (MCU PLL) or word 6 (system PLL) stores data & 0xbfff3fff.
- R5: Writes to words 8, 9 and 10 store the full data. They appear on cfg_gate bits [31:0], [63:32] and [95:64] in that order.
- R6: Word 23 always reads 0x80209828. Writes to it change nothing that can be read.
- R7: Word 18 always reads 0x00004040. Every other word reads 0, and writes to those words change nothing.
- R8: A read returns data on bus_rdata one cycle after the strobe. It returns the value the word held before any write in the same cycle. bus_rdata holds its value while there is no read. It is 0 during reset.
- R9: A write to word 0, 1, 2, 4 or 6 raises recalc_req for exactly the following cycle.
- R10: Writes to words 8 to 10, to word 23 and to unmapped words leave recalc_req low.
- R11: recalc_req is high for the single cycle that follows the first clock edge after reset is released.
- R12: The word index is bus_addr >> 2, so the two low address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| recalc_req | output | 1 | One-cycle frequency recompute request |
| cfg_mode | output | 32 | Stored mode word |
| cfg_pdiv0 | output | 32 | Stored post-divider 0 |
| cfg_pdiv1 | output | 32 | Stored post-divider 1 |
| cfg_mcu_pll | output | 32 | Stored MCU PLL control |
| cfg_sys_pll | output | 32 | Stored system PLL control |
| cfg_gate | output | 96 | Three stored gating words, word 8 lowest |

## Verification
The bench targets these corner cases:

- **Mode bit 26.** The mode word is written with zero and with all ones. A design that applied the mask without forcing bit 26 would read back 0 in that bit.
- **Words that must not change.** Writes go to the power-management word, the constant word and to addresses above the register window. A decoder that compared only low index bits would alias these writes onto real registers.
- **Read and write in the same cycle.** A read-data path that looked at the new value would return the written data instead of the old contents.
- **The recompute request.** It is checked after every operation. A design that pulsed on gating writes, stretched the pulse, or missed the pulse after reset would fail against the expected pattern.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int DW     = 32;
    localparam int NSLOT  = 8;
    localparam int GATE_N = 3;

    typedef logic [DW-1:0] word_t;

    // Word indices the behaviour depends on
    localparam int IDX_CONST = 18;
    localparam int IDX_PM0   = 23;

    localparam word_t CONST_WORD = 32'h0000_4040;
    localparam word_t PM0_WORD   = 32'h8020_9828;

    // Pack PLL fields: pre-divider [29:26], denominator [25:16], integer [13:10], numerator [9:0]
    function automatic word_t pll_pack(int pre, int den, int intg, int num);
        word_t w;
        w = '0;
        w[29:26] = pre[3:0];
        w[25:16] = den[9:0];
        w[13:10] = intg[3:0];
        w[9:0]   = num[9:0];
        return w;
    endfunction

    // Slot table: mode, pdiv0, pdiv1, mcu pll, sys pll, gate0..2
    localparam int SLOT_IDX [NSLOT] = '{0, 1, 2, 4, 6, 8, 9, 10};

    localparam word_t SLOT_RST [NSLOT] = '{
        32'h074b_0b7b, 32'hff87_0b48, 32'h49fc_fe7f,
        pll_pack(1, 0, 6, 0), pll_pack(1, 4, 12, 1),
        32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff};

    localparam word_t SLOT_MASK [NSLOT] = '{
        32'h3b6f_dfff, 32'hff9f_3fff, 32'hffff_ffff,
        32'hbfff_3fff, 32'hbfff_3fff,
        32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff};

    localparam word_t SLOT_SET [NSLOT] = '{
        32'h0400_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};

    localparam bit SLOT_TRIG [NSLOT] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

    localparam int SLOT_GATE0 = 5;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_NOTIFY = 2'd1,
        ST_IDLE   = 2'd2
    } ntf_state_t;

endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
    import clkctl_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             wr,
    output logic [NSLOT-1:0] wr_sel,
    output logic             trig_wr
);
    logic [NSLOT-1:0] trig_mask;

    for (genvar g = 0; g < NSLOT; g++) begin : g_sel
        assign wr_sel[g]    = wr && (idx == IDX_W'(SLOT_IDX[g]));
        assign trig_mask[g] = SLOT_TRIG[g];
    end

    assign trig_wr = |(wr_sel & trig_mask);
endmodule

// File: rtl/clkctl_cfg_word.sv
module clkctl_cfg_word
    import clkctl_pkg::*;
#(
    parameter word_t RST_VAL  = '0,
    parameter word_t WR_MASK  = '1,
    parameter word_t SET_BITS = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  word_t wdata,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= (wdata & WR_MASK) | SET_BITS;
        end
    end
endmodule

// File: rtl/clkctl_rdmux.sv
module clkctl_rdmux
    import clkctl_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0]           idx,
    input  logic [NSLOT-1:0][DW-1:0]   slot_q,
    output word_t                      rd_word
);
    logic [NSLOT-1:0][DW-1:0] hit_word;

    for (genvar g = 0; g < NSLOT; g++) begin : g_hit
        assign hit_word[g] = (idx == IDX_W'(SLOT_IDX[g])) ? slot_q[g] : '0;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NSLOT; i++) begin
            rd_word = rd_word | hit_word[i];
        end
        if (idx == IDX_W'(IDX_CONST)) rd_word = CONST_WORD;
        if (idx == IDX_W'(IDX_PM0))   rd_word = PM0_WORD;
    end
endmodule

// File: rtl/clkctl_notify_fsm.sv
module clkctl_notify_fsm
    import clkctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_wr,
    output logic recalc_req
);
    ntf_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_NOTIFY;
            ST_NOTIFY: state_d = trig_wr ? ST_NOTIFY : ST_IDLE;
            ST_IDLE:   state_d = trig_wr ? ST_NOTIFY : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        recalc_req = 1'b0;
        unique case (state_q)
            ST_NOTIFY: recalc_req = 1'b1;
            ST_BOOT,
            ST_IDLE:   recalc_req = 1'b0;
            default:   recalc_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_rd,
    output logic [31:0]          bus_rdata,
    output logic                 recalc_req,
    output logic [31:0]          cfg_mode,
    output logic [31:0]          cfg_pdiv0,
    output logic [31:0]          cfg_pdiv1,
    output logic [31:0]          cfg_mcu_pll,
    output logic [31:0]          cfg_sys_pll,
    output logic [GATE_N*32-1:0] cfg_gate
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]         idx;
    logic [NSLOT-1:0]         wr_sel;
    logic                     trig_wr;
    logic [NSLOT-1:0][DW-1:0] slot_q;
    word_t                    rd_word;

    assign idx = bus_addr[ADDR_W-1:2];

    clkctl_decode #(.IDX_W(IDX_W)) u_decode (
        .idx     (idx),
        .wr      (bus_wr),
        .wr_sel  (wr_sel),
        .trig_wr (trig_wr)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        clkctl_cfg_word #(
            .RST_VAL  (SLOT_RST[g]),
            .WR_MASK  (SLOT_MASK[g]),
            .SET_BITS (SLOT_SET[g])
        ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_sel[g]),
            .wdata (bus_wdata),
            .q     (slot_q[g])
        );
    end

    clkctl_rdmux #(.IDX_W(IDX_W)) u_rdmux (
        .idx     (idx),
        .slot_q  (slot_q),
        .rd_word (rd_word)
    );

    clkctl_notify_fsm u_notify (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_wr    (trig_wr),
        .recalc_req (recalc_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    assign cfg_mode    = slot_q[0];
    assign cfg_pdiv0   = slot_q[1];
    assign cfg_pdiv1   = slot_q[2];
    assign cfg_mcu_pll = slot_q[3];
    assign cfg_sys_pll = slot_q[4];

    for (genvar k = 0; k < GATE_N; k++) begin : g_gate
        assign cfg_gate[k*32 +: 32] = slot_q[SLOT_GATE0 + k];
    end
endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              recalc_req,
    input logic [31:0]       cfg_mode,
    input logic [31:0]       cfg_mcu_pll,
    input logic [95:0]       cfg_gate
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             freq_wr;
    logic             seen1_q, booted_q;

    assign idx = bus_addr[ADDR_W-1:2];
    assign freq_wr = bus_wr && (idx == IDX_W'(0) || idx == IDX_W'(1) || idx == IDX_W'(2)
                                || idx == IDX_W'(4) || idx == IDX_W'(6));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen1_q  <= 1'b0;
            booted_q <= 1'b0;
        end else begin
            seen1_q  <= 1'b1;
            booted_q <= seen1_q;
        end
    end

    a_r2_mode_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode[26]);

    a_r4_mpll_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_W'(4)) |=> cfg_mcu_pll == ($past(bus_wdata) & 32'hbfff_3fff));

    a_r5_gate1_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_W'(9)) |=> cfg_gate[63:32] == $past(bus_wdata));

    a_r6_pm_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == IDX_W'(23)) |=> bus_rdata == 32'h8020_9828);

    a_r7_const_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == IDX_W'(18)) |=> bus_rdata == 32'h0000_4040);

    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    a_r9_notify: assert property (@(posedge clk) disable iff (!rst_n)
        freq_wr |=> recalc_req);

    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (booted_q && !$past(freq_wr)) |-> !recalc_req);
endmodule

bind clkctl_regbank clkctl_regbank_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .recalc_req  (recalc_req),
    .cfg_mode    (cfg_mode),
    .cfg_mcu_pll (cfg_mcu_pll),
    .cfg_gate    (cfg_gate)
);

// File: tb/clkctl_regbank_tb_top.sv
module clkctl_regbank_tb_top;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              recalc_req;
    logic [31:0]       cfg_mode, cfg_pdiv0, cfg_pdiv1, cfg_mcu_pll, cfg_sys_pll;
    logic [95:0]       cfg_gate;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] mreg [32];
    logic [31:0] last_rd;

    always #5 clk = ~clk;

    clkctl_regbank #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .recalc_req(recalc_req), .cfg_mode(cfg_mode), .cfg_pdiv0(cfg_pdiv0),
        .cfg_pdiv1(cfg_pdiv1), .cfg_mcu_pll(cfg_mcu_pll), .cfg_sys_pll(cfg_sys_pll),
        .cfg_gate(cfg_gate)
    );

    task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
        mreg[0]  = 32'h074b_0b7b;
        mreg[1]  = 32'hff87_0b48;
        mreg[2]  = 32'h49fc_fe7f;
        mreg[4]  = 32'h0400_1800;
        mreg[6]  = 32'h0404_3001;
        mreg[8]  = 32'hffff_ffff;
        mreg[9]  = 32'hffff_ffff;
        mreg[10] = 32'hffff_ffff;
    endfunction

    function automatic logic [31:0] exp_read(int idx);
        if (idx == 18) return 32'h0000_4040;
        if (idx == 23) return 32'h8020_9828;
        if (idx inside {0, 1, 2, 4, 6, 8, 9, 10}) return mreg[idx];
        return 32'h0;
    endfunction

    function automatic void model_write(int idx, logic [31:0] d);
        case (idx)
            0:        mreg[0] = (d & 32'h3b6f_dfff) | 32'h0400_0000;
            1:        mreg[1] = d & 32'hff9f_3fff;
            2:        mreg[2] = d;
            4, 6:     mreg[idx] = d & 32'hbfff_3fff;
            8, 9, 10: mreg[idx] = d;
            default:  ;
        endcase
    endfunction

    function automatic bit is_trig(int idx);
        return idx inside {0, 1, 2, 4, 6};
    endfunction

    function automatic string rd_tag(int idx);
        if (idx == 0) return "R2";
        if (idx == 1 || idx == 2) return "R3";
        if (idx == 4 || idx == 6) return "R4";
        if (idx inside {8, 9, 10}) return "R5";
        if (idx == 23) return "R6";
        return "R7";
    endfunction

    task automatic check_cfg();
        check("R2 cfg_mode", {64'h0, cfg_mode}, {64'h0, mreg[0]});
        check("R3 cfg_pdiv", {32'h0, cfg_pdiv1, cfg_pdiv0}, {32'h0, mreg[2], mreg[1]});
        check("R4 cfg_pll", {32'h0, cfg_sys_pll, cfg_mcu_pll}, {32'h0, mreg[6], mreg[4]});
        check("R5 cfg_gate", cfg_gate, {mreg[10], mreg[9], mreg[8]});
    endtask

    // Called at a negedge; drives one bus cycle and checks at the next negedge
    task automatic do_op(bit rd, bit wr, logic [ADDR_W-1:0] addr, logic [31:0] d, string tag);
        int idx;
        logic [31:0] exp_rd;
        idx = int'(addr >> 2);
        exp_rd = rd ? exp_read(idx) : last_rd;
        bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = d;
        @(negedge clk);
        if (rd) check({tag, " ", rd_tag(idx), " read"}, {64'h0, bus_rdata}, {64'h0, exp_rd});
        else    check({tag, " R8 hold"}, {64'h0, bus_rdata}, {64'h0, exp_rd});
        last_rd = exp_rd;
        check({tag, (wr && is_trig(idx)) ? " R9" : " R10", " recalc"},
              {95'h0, recalc_req}, {95'h0, wr && is_trig(idx)});
        if (wr) model_write(idx, d);
        check_cfg();
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        last_rd = 32'h0;
        repeat (3) @(negedge clk);
        check("R8 reset rdata", {64'h0, bus_rdata}, 96'h0);
        check("R11 reset req", {95'h0, recalc_req}, 96'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 boot pulse", {95'h0, recalc_req}, 96'h1);
        @(negedge clk);
        check("R11 pulse ends", {95'h0, recalc_req}, 96'h0);
        check_cfg();

        // R1: reset contents through reads
        foreach (mreg[i]) begin
            if (i inside {0, 1, 2, 4, 6, 8, 9, 10, 23})
                do_op(1'b1, 1'b0, ADDR_W'(i * 4), 32'h0, "R1");
        end
        do_op(1'b1, 1'b0, ADDR_W'(18 * 4), 32'h0, "R7");
        do_op(1'b1, 1'b0, ADDR_W'(3 * 4), 32'h0, "R7");

        // Directed corners
        do_op(1'b0, 1'b1, ADDR_W'(0), 32'h0, "R2");
        do_op(1'b1, 1'b0, ADDR_W'(0), 32'h0, "R2");
        do_op(1'b0, 1'b1, ADDR_W'(0), 32'hffff_ffff, "R2");
        do_op(1'b0, 1'b1, ADDR_W'(1 * 4), 32'hffff_ffff, "R3");
        do_op(1'b0, 1'b1, ADDR_W'(23 * 4), 32'h0, "R6");
        do_op(1'b1, 1'b0, ADDR_W'(23 * 4), 32'h0, "R6");
        do_op(1'b0, 1'b1, ADDR_W'(18 * 4), 32'h0, "R7");
        do_op(1'b1, 1'b0, ADDR_W'(18 * 4), 32'h0, "R7");
        do_op(1'b0, 1'b1, ADDR_W'(1023 * 4 + 2), 32'h1234_5678, "R7");
        do_op(1'b0, 1'b1, ADDR_W'(4 * 4 + 3), 32'hffff_ffff, "R12");
        do_op(1'b1, 1'b0, ADDR_W'(4 * 4), 32'h0, "R12");
        do_op(1'b1, 1'b1, ADDR_W'(9 * 4), 32'h0bad_cafe, "R8");
        do_op(1'b1, 1'b0, ADDR_W'(9 * 4 + 1), 32'h0, "R8");
        do_op(1'b0, 1'b1, ADDR_W'(8 * 4), 32'h5555_aaaa, "R10");
        do_op(1'b0, 1'b1, ADDR_W'(6 * 4), 32'hdead_beef, "R9");
        do_op(1'b0, 1'b1, ADDR_W'(2 * 4), 32'hdead_beef, "R9");
        do_op(1'b0, 1'b0, ADDR_W'(0), 32'h0, "R9");

        // Constrained random
        for (int n = 0; n < 1500; n++) begin
            logic [ADDR_W-1:0] a;
            logic [31:0] d;
            bit rd, wr;
            if ($urandom % 8 == 0) a = ADDR_W'($urandom);
            else a = ADDR_W'((($urandom % 32) << 2) | ($urandom % 4));
            d  = ($urandom % 10 == 0) ? 32'hffff_ffff : $urandom;
            rd = ($urandom % 2) == 1;
            wr = ($urandom % 3) != 0;
            do_op(rd, wr, a, d, "rand");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule